// File: doc/BRIEF.md
# Transmit Packet Buffer Framer

This block moves one outgoing Ethernet frame from a byte stream into a paged packet memory and hands it to the transmit queue. When the first byte of a frame is offered, it reads the declared frame length and pads short frames up to the minimum. It then works out the allocation size in 256-byte pages and asks the memory manager for a packet slot. Once a slot is granted, it writes 16-bit words into the slot, starting at word zero and advancing one word per write. The words are a zero status word, the stored byte count, the payload packed two bytes per word, and a closing control word.

After the closing word it pulses an enqueue command. It then waits for the transmitter to report completion, or for a timeout. Next it pulses a free command and waits until the memory manager is no longer busy. Finally it reports the outcome on a one-cycle pass or fail pulse. A frame that is too large, or whose allocation cannot be obtained, is drained from the stream without any memory write and reported as failed.

Frame bytes use valid/ready handshaking. A byte moves on a clock edge where `s_valid` and `s_ready` are both high. The producer holds `s_valid`, `s_data`, `s_last` and `s_len` stable until that edge, and keeps `s_len` constant for the whole frame. The block holds `s_ready` low while it sizes the frame, allocates the slot, writes the header and closes the frame. It raises `s_ready` only while it stores payload bytes or drains a rejected frame. It takes no new frame until the pass or fail pulse has been given.

Top module: `txf_framer`

## Requirements
- R1: A frame whose declared length L is below 60 is stored as 60 bytes, and byte positions L..59 hold zero. The padded length is P = max(L, 60).
- R2: While `alloc_req` is high, `alloc_pages` equals ((P with bit 0 cleared) + 6) >> 8, which is the page count minus one.
- R3: If that page value is above 7, no allocation is requested and no word is written. The frame's bytes are still accepted up to the one flagged `s_last`, and `done_err` pulses in the cycle that byte is taken.
- R4: Word 0 of the slot is 0x0000. Word 1 is P + 6.
- R5: Payload words follow from word 2 on. Word 2+k holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. Each write goes to the address after the previous one, every write carries the granted packet number on `pkt_id`, and a frame writes 3 + floor(P/2) words in all.
- R6: The last word, at address 2 + floor(P/2), is 0x0000 when P is even. When P is odd it holds byte P-1 in bits 7:0 with bit 13 set, i.e. 0x2000 | byte.
- R7: Each allocation attempt is one `alloc_req` cycle followed by a 16-cycle window in which `alloc_ack` is sampled, so successive requests are 17 cycles apart. After 5 attempts without an acknowledge, the frame is drained and `done_err` pulses.
- R8: An acknowledge with `alloc_fail` high ends the allocation at once, with no further request. The frame is then drained and reported as failed.
- R9: `cmd_enq` pulses for one cycle after the last word is written. If `tx_done` is seen in cycle e+1+d, where e is the `cmd_enq` cycle, `cmd_free` pulses in cycle e+2+d. If `tx_done` never comes, `cmd_free` pulses 257 cycles after `cmd_enq`. Once `mmu_busy` has been low for one sampled cycle after the free, the outcome pulses: `done_ok` if `tx_done` was seen, otherwise `done_err`.
- R10: `s_ready` is low after reset, and low during sizing, allocation and header writes. No payload byte is accepted before the header words are written.
- R11: Each frame produces exactly one one-cycle pulse, on either `done_ok` or `done_err`, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Frame byte valid |
| s_ready | output | 1 | Block accepts a frame byte |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Marks the final byte of the frame |
| s_len | input | 12 | Declared frame length in bytes (at least 1), stable through the frame |
| alloc_req | output | 1 | One-cycle allocation request |
| alloc_pages | output | 3 | Requested size in pages minus one |
| alloc_ack | input | 1 | Allocation answer present |
| alloc_fail | input | 1 | The answered packet number is marked failed |
| alloc_pkt | input | 6 | Granted packet number |
| ram_we | output | 1 | Packet memory word write |
| ram_addr | output | 10 | Word address inside the packet slot |
| ram_wdata | output | 16 | Word to write |
| pkt_id | output | 6 | Packet number for writes and commands |
| cmd_enq | output | 1 | Enqueue command pulse |
| cmd_free | output | 1 | Free-packet command pulse |
| tx_done | input | 1 | Transmit completion |
| mmu_busy | input | 1 | Memory manager busy |
| done_ok | output | 1 | Frame sent pulse |
| done_err | output | 1 | Frame failed pulse |

## Verification
The hardest situation to reach from the ports is an allocation that fails or succeeds only at the edge of the retry limit. Examples are an acknowledge in the very last poll cycle of the fifth attempt, and five silent windows in a row, each needing the rest of the frame to be drained afterwards. The bench's memory-manager responder can be told to ignore a chosen number of requests and to answer after a chosen delay, with or without the failed flag. Directed frames place the answer at poll cycle 15 of attempt 5 and also ignore all five attempts, while random frames mix these settings with odd, even, short and oversized lengths.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ALLOC, ST_HDR0, ST_HDR1, ST_DATA, ST_PAD,
    ST_CTRL, ST_ENQ, ST_WTX, ST_FREE, ST_WBSY, ST_DRAIN
  } fr_st_e;

  typedef enum logic [1:0] {AL_IDLE, AL_REQ, AL_POLL} al_st_e;
endpackage

// File: rtl/txf_sizer.sv
module txf_sizer #(
  parameter int LEN_W      = 12,
  parameter int MIN_LEN    = 60,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_PAGES  = 8,
  parameter int OVERHEAD   = 6,
  parameter int PG_W       = 3
) (
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] padded,
  output logic [PG_W-1:0]  page_code,
  output logic             too_big,
  output logic [15:0]      byte_cnt
);
  localparam int SH   = $clog2(PAGE_BYTES);
  localparam int FW   = LEN_W + 1 - SH;

  logic [LEN_W:0] span;
  logic [FW-1:0]  pg_full;

  always_comb begin
    padded    = (len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : len;
    span      = {1'b0, padded[LEN_W-1:1], 1'b0} + (LEN_W+1)'(OVERHEAD);
    pg_full   = span[LEN_W:SH];
    too_big   = pg_full > FW'(MAX_PAGES - 1);
    page_code = pg_full[PG_W-1:0];
    byte_cnt  = 16'(padded) + 16'(OVERHEAD);
  end
endmodule

// File: rtl/txf_alloc.sv
module txf_alloc
  import txf_pkg::*;
#(
  parameter int POLL_WIN = 16,
  parameter int MAX_TRY  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic alloc_ack,
  input  logic alloc_fail,
  output logic alloc_req,
  output logic granted,
  output logic refused
);
  localparam int PW = (POLL_WIN > 1) ? $clog2(POLL_WIN) : 1;
  localparam int TW = (MAX_TRY > 1) ? $clog2(MAX_TRY) : 1;

  al_st_e        st;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tries;
  logic          win_end, last_try;

  assign win_end   = pcnt == PW'(POLL_WIN - 1);
  assign last_try  = tries == TW'(MAX_TRY - 1);
  assign alloc_req = st == AL_REQ;
  assign granted   = (st == AL_POLL) && alloc_ack && !alloc_fail;
  assign refused   = (st == AL_POLL) &&
                     ((alloc_ack && alloc_fail) || (!alloc_ack && win_end && last_try));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= AL_IDLE;
      pcnt  <= '0;
      tries <= '0;
    end else begin
      case (st)
        AL_IDLE: if (start) begin
          st    <= AL_REQ;
          tries <= '0;
        end
        AL_REQ: begin
          pcnt <= '0;
          st   <= AL_POLL;
        end
        AL_POLL: begin
          if (alloc_ack || (win_end && last_try)) st <= AL_IDLE;
          else if (win_end) begin
            tries <= tries + 1'b1;
            st    <= AL_REQ;
          end else pcnt <= pcnt + 1'b1;
        end
        default: st <= AL_IDLE;
      endcase
    end
  end

  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> !alloc_req);
  assert_no_retry_after_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> !alloc_req);
endmodule

// File: rtl/txf_framer.sv
module txf_framer
  import txf_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PKT_W      = 6,
  parameter int MIN_LEN    = 60,
  parameter int PAGE_BYTES = 256,
  parameter int MAX_PAGES  = 8,
  parameter int POLL_WIN   = 16,
  parameter int MAX_TRY    = 5,
  parameter int TX_TMO     = 256,
  localparam int PG_W      = $clog2(MAX_PAGES),
  localparam int WA_W      = $clog2(PAGE_BYTES * MAX_PAGES / 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  input  logic [LEN_W-1:0] s_len,
  output logic             alloc_req,
  output logic [PG_W-1:0]  alloc_pages,
  input  logic             alloc_ack,
  input  logic             alloc_fail,
  input  logic [PKT_W-1:0] alloc_pkt,
  output logic             ram_we,
  output logic [WA_W-1:0]  ram_addr,
  output logic [15:0]      ram_wdata,
  output logic [PKT_W-1:0] pkt_id,
  output logic             cmd_enq,
  output logic             cmd_free,
  input  logic             tx_done,
  input  logic             mmu_busy,
  output logic             done_ok,
  output logic             done_err
);
  localparam int TM_W        = (TX_TMO > 1) ? $clog2(TX_TMO) : 1;
  localparam int PAD_END     = 2 + MIN_LEN / 2;
  localparam logic [15:0] ODD_FLAG = 16'h2000;

  fr_st_e           st;
  logic [LEN_W-1:0] len_q, pad_q, idx, sz_pad;
  logic [PG_W-1:0]  pg_q, sz_pg;
  logic [15:0]      bc_q, sz_bc;
  logic             sz_big, al_start, al_ok, al_bad, acc, last_b, ok_q, fin;
  logic [7:0]       lo_q;
  logic [WA_W-1:0]  waddr;
  logic [TM_W-1:0]  tmo;

  txf_sizer #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .PAGE_BYTES(PAGE_BYTES),
              .MAX_PAGES(MAX_PAGES), .OVERHEAD(6), .PG_W(PG_W)) sizer_i (
    .len(s_len), .padded(sz_pad), .page_code(sz_pg), .too_big(sz_big), .byte_cnt(sz_bc));

  txf_alloc #(.POLL_WIN(POLL_WIN), .MAX_TRY(MAX_TRY)) alloc_i (
    .clk(clk), .rst_n(rst_n), .start(al_start), .alloc_ack(alloc_ack),
    .alloc_fail(alloc_fail), .alloc_req(alloc_req), .granted(al_ok), .refused(al_bad));

  assign al_start    = (st == ST_IDLE) && s_valid && !sz_big;
  assign alloc_pages = pg_q;
  assign s_ready     = (st == ST_DATA) || (st == ST_DRAIN);
  assign acc         = s_valid && s_ready;
  assign last_b      = idx == LEN_W'(len_q - 1'b1);
  assign ram_addr    = waddr;
  assign pkt_id      = pkt_q;
  assign cmd_enq     = st == ST_ENQ;
  assign cmd_free    = st == ST_FREE;
  assign fin         = (st == ST_WBSY) && !mmu_busy;
  assign done_ok     = fin && ok_q;
  assign done_err    = (fin && !ok_q) || ((st == ST_DRAIN) && acc && s_last);

  logic [PKT_W-1:0] pkt_q;

  always_comb begin
    ram_we    = 1'b0;
    ram_wdata = '0;
    case (st)
      ST_HDR0: ram_we = 1'b1;
      ST_HDR1: begin ram_we = 1'b1; ram_wdata = bc_q; end
      ST_DATA: if (acc) begin
        if (idx[0]) begin
          ram_we = 1'b1; ram_wdata = {s_data, lo_q};
        end else if (idx == LEN_W'(pad_q - 1'b1)) begin
          ram_we = 1'b1; ram_wdata = ODD_FLAG | {8'h00, s_data};
        end else if (last_b) begin
          ram_we = 1'b1; ram_wdata = {8'h00, s_data};
        end
      end
      ST_PAD, ST_CTRL: ram_we = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; len_q <= '0; pad_q <= '0; pg_q <= '0; bc_q <= '0;
      idx <= '0; lo_q <= '0; waddr <= '0; tmo <= '0; ok_q <= 1'b0; pkt_q <= '0;
    end else begin
      if (ram_we) waddr <= waddr + 1'b1;
      case (st)
        ST_IDLE: begin
          waddr <= '0;
          idx   <= '0;
          if (s_valid) begin
            len_q <= s_len; pad_q <= sz_pad; pg_q <= sz_pg; bc_q <= sz_bc;
            st    <= sz_big ? ST_DRAIN : ST_ALLOC;
          end
        end
        ST_ALLOC: begin
          if (al_ok) begin pkt_q <= alloc_pkt; st <= ST_HDR0; end
          else if (al_bad) st <= ST_DRAIN;
        end
        ST_HDR0: st <= ST_HDR1;
        ST_HDR1: st <= ST_DATA;
        ST_DATA: if (acc) begin
          idx  <= idx + 1'b1;
          lo_q <= s_data;
          if (last_b) begin
            if (!idx[0] && len_q >= LEN_W'(MIN_LEN)) st <= ST_ENQ;
            else if (len_q < LEN_W'(MIN_LEN) && waddr != WA_W'(PAD_END - 1)) st <= ST_PAD;
            else st <= ST_CTRL;
          end
        end
        ST_PAD:  if (waddr == WA_W'(PAD_END - 1)) st <= ST_CTRL;
        ST_CTRL: st <= ST_ENQ;
        ST_ENQ: begin tmo <= '0; st <= ST_WTX; end
        ST_WTX: begin
          if (tx_done) begin ok_q <= 1'b1; st <= ST_FREE; end
          else if (tmo == TM_W'(TX_TMO - 1)) begin ok_q <= 1'b0; st <= ST_FREE; end
          else tmo <= tmo + 1'b1;
        end
        ST_FREE: st <= ST_WBSY;
        ST_WBSY: if (!mmu_busy) st <= ST_IDLE;
        ST_DRAIN: if (acc && s_last) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_err));
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> (!ram_we || ram_addr == WA_W'($past(ram_addr) + 1'b1)));
  assert_enq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_enq |=> (!cmd_enq && !ram_we && !s_ready));
  assert_free_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_free |=> !cmd_free);
  assert_ready_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> !s_ready);
endmodule

// File: tb/txf_framer_tb_top.sv
`timescale 1ns/1ps
module txf_framer_tb_top;
  localparam int POLL_WIN = 16;
  localparam int TX_TMO   = 256;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic [11:0] s_len = '0;
  logic alloc_ack = 1'b0, alloc_fail = 1'b0, tx_done = 1'b0, mmu_busy = 1'b0;
  logic [5:0] alloc_pkt = '0;
  logic s_ready, alloc_req, ram_we, cmd_enq, cmd_free, done_ok, done_err;
  logic [2:0] alloc_pages;
  logic [9:0] ram_addr;
  logic [15:0] ram_wdata;
  logic [5:0] pkt_id;

  txf_framer dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_len(s_len), .alloc_req(alloc_req), .alloc_pages(alloc_pages),
    .alloc_ack(alloc_ack), .alloc_fail(alloc_fail), .alloc_pkt(alloc_pkt), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .pkt_id(pkt_id), .cmd_enq(cmd_enq),
    .cmd_free(cmd_free), .tx_done(tx_done), .mmu_busy(mmu_busy), .done_ok(done_ok),
    .done_err(done_err));

  int n_chk = 0, n_fail = 0;
  int cfg_ign, cfg_dly, cfg_txd, cfg_busy;
  bit cfg_afail, cfg_txnever;
  logic [5:0] cfg_pkt;
  int cyc, wr_cnt, req_cnt, enq_cnt, free_cnt, ok_cnt, err_cnt, both_cnt, busy_bad;
  int early_acc, pkt_bad, gap_bad, last_req, enq_cyc, free_cyc, done_cyc, pages_cap;
  int req_dly, tx_dly, busy_cnt;
  bit req_wait, tx_wait;
  logic [7:0] fb [0:2047];
  logic [15:0] mem [0:1023];

  task automatic chk(bit c, string tag, longint act, longint exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic watchdog();
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  endtask

  task automatic env_loop();
    forever begin
      @(negedge clk);
      cyc++;
      if (ram_we) begin mem[ram_addr] = ram_wdata; wr_cnt++; end
      if ((ram_we || cmd_enq || cmd_free) && pkt_id != cfg_pkt) pkt_bad++;
      if (s_valid && s_ready && wr_cnt == 0) early_acc++;
      if (alloc_req) begin
        if (req_cnt > 0 && cyc - last_req != POLL_WIN + 1) gap_bad++;
        last_req = cyc; req_cnt++; pages_cap = int'(alloc_pages);
        req_wait = 1; req_dly = cfg_dly;
      end
      if (cmd_enq) begin enq_cnt++; enq_cyc = cyc; tx_wait = 1; tx_dly = cfg_txd; end
      if (cmd_free) begin free_cnt++; free_cyc = cyc; busy_cnt = cfg_busy; end
      if (done_ok) ok_cnt++;
      if (done_err) err_cnt++;
      if (done_ok && done_err) both_cnt++;
      if ((done_ok || done_err) && mmu_busy) busy_bad++;
      if (done_ok || done_err) done_cyc = cyc;
      @(posedge clk); #1;
      alloc_ack = 0; alloc_fail = 0; alloc_pkt = cfg_pkt;
      if (req_wait && req_cnt > cfg_ign) begin
        if (req_dly == 0) begin alloc_ack = 1; alloc_fail = cfg_afail; req_wait = 0; end
        else req_dly--;
      end
      tx_done = 0;
      if (tx_wait && !cfg_txnever) begin
        if (tx_dly == 0) begin tx_done = 1; tx_wait = 0; end
        else tx_dly--;
      end
      mmu_busy = busy_cnt > 0;
      if (busy_cnt > 0) busy_cnt--;
    end
  endtask

  task automatic send_frame(int len, int gap);
    for (int i = 0; i < len; i++) begin
      while ($urandom_range(99) < gap) begin
        s_valid = 0; @(posedge clk); #1;
      end
      s_valid = 1; s_data = fb[i]; s_last = (i == len - 1);
      do @(negedge clk); while (!s_ready);
      @(posedge clk); #1;
    end
    s_valid = 0; s_last = 0;
  endtask

  function automatic logic [7:0] bt(int j, int len);
    return (j < len) ? fb[j] : 8'h00;
  endfunction

  task automatic run_frame(int len, int ign, int dly, bit afail, int txd, bit txnever,
                           int busy, int gap);
    int p, pg, nw, bad, w;
    bit big, granted, exp_ok;
    logic [15:0] fin_exp;
    p = (len < 60) ? 60 : len;
    pg = ((p & ~1) + 6) >> 8;
    big = pg > 7;
    granted = !big && ign < 5 && !afail;
    exp_ok = granted && !txnever;
    nw = 3 + p / 2;
    cfg_ign = ign; cfg_dly = dly; cfg_afail = afail; cfg_txd = txd;
    cfg_txnever = txnever; cfg_busy = busy; cfg_pkt = 6'($urandom_range(63));
    wr_cnt = 0; req_cnt = 0; enq_cnt = 0; free_cnt = 0; ok_cnt = 0; err_cnt = 0;
    both_cnt = 0; busy_bad = 0; early_acc = 0; pkt_bad = 0; gap_bad = 0;
    req_wait = 0; tx_wait = 0; busy_cnt = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'hDEAD;
    for (int i = 0; i < 2048; i++) fb[i] = 8'($urandom_range(255));
    s_len = 12'(len);
    send_frame(len, gap);
    w = 0;
    while (ok_cnt + err_cnt == 0 && w < 4000) begin @(posedge clk); w++; end
    repeat (4) @(posedge clk);
    #1;
    chk(ok_cnt + err_cnt == 1 && both_cnt == 0, "R11 single status pulse",
        ok_cnt + err_cnt, 1);
    chk(ok_cnt == int'(exp_ok), "R9 outcome", ok_cnt, exp_ok);
    chk(req_cnt == (big ? 0 : (ign >= 5 ? 5 : ign + 1)),
        big ? "R3 no request" : (afail ? "R8 attempts" : "R7 attempts"),
        req_cnt, big ? 0 : (ign >= 5 ? 5 : ign + 1));
    if (req_cnt > 1) chk(gap_bad == 0, "R7 request spacing", gap_bad, 0);
    if (!big) chk(pages_cap == pg, "R2 page request", pages_cap, pg);
    if (granted) begin
      chk(wr_cnt == nw && pkt_bad == 0, "R5 write count", wr_cnt, nw);
      chk(mem[0] == 16'h0 && mem[1] == 16'(p + 6), "R4 header", {mem[0], mem[1]},
          {16'h0, 16'(p + 6)});
      bad = 0;
      for (int k = 0; k < p / 2; k++)
        if (mem[2 + k] != {bt(2 * k + 1, len), bt(2 * k, len)}) bad++;
      chk(bad == 0, (len < 60) ? "R1 padded payload" : "R5 payload packing", bad, 0);
      fin_exp = (p % 2 == 1) ? (16'h2000 | {8'h00, bt(p - 1, len)}) : 16'h0000;
      chk(mem[2 + p / 2] == fin_exp, "R6 final word", mem[2 + p / 2], fin_exp);
      chk(early_acc == 0, "R10 no byte before header", early_acc, 0);
      chk(enq_cnt == 1 && free_cnt == 1, "R9 enqueue and free", enq_cnt * 16 + free_cnt,
          17);
      chk(free_cyc - enq_cyc == (txnever ? TX_TMO + 1 : txd + 2), "R9 free timing",
          free_cyc - enq_cyc, txnever ? TX_TMO + 1 : txd + 2);
      chk(done_cyc - free_cyc == busy + 1 && busy_bad == 0, "R9 busy wait",
          done_cyc - free_cyc, busy + 1);
    end else begin
      chk(wr_cnt == 0 && enq_cnt == 0 && free_cnt == 0,
          big ? "R3 no write" : (afail ? "R8 no write" : "R7 no write"), wr_cnt, 0);
    end
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cfg_pkt = '0; cyc = 0;
    fork
      watchdog();
      env_loop();
    join_none
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!s_ready && !alloc_req && !ram_we && !cmd_enq && !cmd_free && !done_ok && !done_err,
        "R10 reset state", {s_ready, alloc_req, ram_we, cmd_enq, done_ok, done_err}, 0);
    @(posedge clk); #1;
    // directed corners: short, minimum, odd, page edges, size limit, retries
    run_frame(1, 0, 0, 0, 3, 0, 0, 0);
    run_frame(59, 0, 2, 0, 0, 0, 1, 10);
    run_frame(60, 0, 0, 0, 5, 0, 0, 0);
    run_frame(61, 0, 1, 0, 2, 0, 2, 0);
    run_frame(249, 0, 0, 0, 1, 0, 0, 5);
    run_frame(250, 0, 0, 0, 1, 0, 0, 0);
    run_frame(2041, 0, 0, 0, 0, 0, 0, 0);
    run_frame(2042, 0, 0, 0, 0, 0, 0, 0);
    run_frame(100, 2, 3, 0, 4, 0, 0, 0);
    run_frame(90, 4, 15, 0, 0, 0, 0, 0);
    run_frame(80, 5, 0, 0, 0, 0, 0, 0);
    run_frame(70, 1, 0, 1, 0, 0, 0, 0);
    run_frame(64, 0, 0, 0, 0, 1, 3, 0);
    run_frame(120, 0, 0, 0, 0, 0, 9, 20);
    // constrained random frames
    for (int n = 0; n < 40; n++) begin
      int len, ign;
      len = ($urandom_range(99) < 10) ? int'($urandom_range(2100, 2030))
                                      : int'($urandom_range(400, 1));
      ign = ($urandom_range(99) < 85) ? 0 : int'($urandom_range(5, 1));
      run_frame(len, ign, int'($urandom_range(12)), $urandom_range(99) < 5,
                int'($urandom_range(30)), $urandom_range(99) < 5,
                int'($urandom_range(6)), int'($urandom_range(30)));
    end
    finish_run();
  end
endmodule